// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Sequencer

This block is the control unit and a minimal datapath of a 16-bit stored-program processor. Each instruction is walked through six phases, one after another: fetch, decode, evaluate address, fetch operands, execute and store result. When the last phase ends, the sequencer starts the next fetch. The block holds its own program counter, instruction register, memory address and memory data registers, and eight general registers. A two-bit select picks one of three ALU functions: add, bitwise AND or bitwise NOT. A gate decides in which cycle the ALU output, or the memory data register, drives the internal result bus.

Memory is a single read port with a request/ready handshake. The sequencer raises a request and stays in the same step until memory answers, so every read can take any number of cycles. Only register-to-register arithmetic and a base-plus-offset load are carried out. Every other opcode still passes through all six phases but writes nothing.

Top module: `instr_cycle_seq`

## Requirements
- R1: The `phase` output steps through fetch=0, decode=1, evaluate-address=2, fetch-operands=3, execute=4, store-result=5 in that order, and after 5 it returns to 0.
- R2: While `rst_n` is low, `phase` is 0, `pc` is 0x3000, `mem_req` and `wb_valid` are low, and all eight general registers are cleared to zero.
- R3: In the first fetch cycle, `pc` shows the instruction's address, and that address is also loaded as the read address. From the next cycle on, `pc` shows the address plus one.
- R4: During the instruction read, `mem_req` stays high and `mem_addr` stays stable until the cycle in which `mem_ready` is sampled high. Fetch lasts 3 cycles plus the number of wait cycles.
- R5: Opcode bits [15:12]=0001 (ADD) write to register [11:9] the sum modulo 2^16 of register [8:6] and register [2:0]. Bits [5:3] are ignored.
- R6: Opcode 0101 (AND) writes the bitwise AND of register [8:6] and register [2:0] to register [11:9].
- R7: Opcode 1001 (NOT) writes the bitwise complement of register [8:6] to register [11:9]. Bits [5:0] are ignored.
- R8: Opcode 0110 (load) forms the address as register [8:6] plus bits [5:0] sign-extended, modulo 2^16. It reads that address in the fetch-operands phase using the same handshake, and writes the read word to register [11:9].
- R9: Any other opcode makes no register write and takes no operand read. Each phase after fetch still lasts one cycle.
- R10: `wb_valid` is high only in the store-result cycle. `wb_reg` and `wb_data` give the destination and its new value there, and the written value is used by every later instruction.
- R11: An instruction takes 8 cycles plus the fetch wait cycles. A load takes 8 cycles plus the wait cycles of both of its reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 16 | Read address (memory address register) |
| mem_rdata | input | 16 | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Memory answers the current request |
| phase | output | 3 | Current instruction phase, encoded as in R1 |
| pc | output | 16 | Program counter |
| wb_valid | output | 1 | A register write takes place this cycle |
| wb_reg | output | 3 | Destination register of the write |
| wb_data | output | 16 | Value being written |

## Verification
In the first fetch cycle, two transfers happen on the same clock edge: the address register captures the program counter, and the counter itself advances. A wrong ordering would read the instruction one word too far on. The bench checks the `pc` output in every cycle against the model, both the pre-increment value in the first fetch cycle and the incremented value afterwards. On every read it also compares `mem_addr` with the address the model expects. The memory's wait states are varied from 0 to 3 cycles from one access to the next, so the fetch read and the load's operand read each meet both immediate and delayed answers.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_FMAR = 4'd0,
    ST_FMEM = 4'd1,
    ST_FIR  = 4'd2,
    ST_DEC  = 4'd3,
    ST_EVA  = 4'd4,
    ST_OPS  = 4'd5,
    ST_EXE  = 4'd6,
    ST_STO  = 4'd7
  } state_e;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EVAL   = 3'd2,
    PH_OPER   = 3'd3,
    PH_EXEC   = 3'd4,
    PH_STORE  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_AND = 2'b01,
    ALU_NOT = 2'b10
  } alu_sel_e;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam logic [3:0] OPC_LDR = 4'b0110;

  typedef struct packed {
    logic     mar_from_pc;
    logic     pc_inc;
    logic     mdr_load;
    logic     ir_load;
    logic     mar_from_ea;
    logic     opnd_load;
    logic     gate_alu;
    logic     gate_mdr;
    logic     res_load;
    logic     rf_write;
    logic     mem_req;
    alu_sel_e alu_sel;
  } ctrl_t;

endpackage

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_sel_e      sel,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (sel)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DW = 16,
  parameter int NR = 8,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] regs [NR];

  generate
    for (genvar i = 0; i < NR; i++) begin : g_reg
      logic hit;
      assign hit = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs[i] <= '0;
        end else if (hit) begin
          regs[i] <= wdata;
        end
      end
    end
  endgenerate

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int OPW = 4,
  localparam int NOPS = 1 << OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mem_ready,
  input  logic [OPW-1:0] opcode,
  output ctrl_t          ctl,
  output phase_e         phase
);

  localparam logic [NOPS-1:0] KNOWN_MASK =
    (NOPS'(1) << OPC_ADD) | (NOPS'(1) << OPC_AND) |
    (NOPS'(1) << OPC_NOT) | (NOPS'(1) << OPC_LDR);

  state_e         state_q, state_d;
  logic [NOPS-1:0] op_hot;
  logic           is_add, is_and, is_not, is_ldr, is_alu, is_nop;

  generate
    for (genvar k = 0; k < NOPS; k++) begin : g_dec
      assign op_hot[k] = (opcode == OPW'(k));
    end
  endgenerate

  assign is_add = op_hot[OPC_ADD];
  assign is_and = op_hot[OPC_AND];
  assign is_not = op_hot[OPC_NOT];
  assign is_ldr = op_hot[OPC_LDR];
  assign is_alu = is_add | is_and | is_not;
  assign is_nop = |(op_hot & ~KNOWN_MASK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FMAR: state_d = ST_FMEM;
      ST_FMEM: if (mem_ready) state_d = ST_FIR;
      ST_FIR:  state_d = ST_DEC;
      ST_DEC:  state_d = ST_EVA;
      ST_EVA:  state_d = ST_OPS;
      ST_OPS:  if (!is_ldr || mem_ready) state_d = ST_EXE;
      ST_EXE:  state_d = ST_STO;
      ST_STO:  state_d = ST_FMAR;
      default: state_d = ST_FMAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FMAR;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.alu_sel = is_and ? ALU_AND : (is_not ? ALU_NOT : ALU_ADD);
    unique case (state_q)
      ST_FMAR: begin
        ctl.mar_from_pc = 1'b1;
        ctl.pc_inc      = 1'b1;
      end
      ST_FMEM: begin
        ctl.mem_req  = 1'b1;
        ctl.mdr_load = mem_ready;
      end
      ST_FIR:  ctl.ir_load = 1'b1;
      ST_EVA:  ctl.mar_from_ea = is_ldr;
      ST_OPS: begin
        ctl.opnd_load = is_alu;
        ctl.mem_req   = is_ldr;
        ctl.mdr_load  = is_ldr & mem_ready;
      end
      ST_EXE: begin
        ctl.gate_alu = is_alu;
        ctl.gate_mdr = is_ldr;
        ctl.res_load = is_alu | is_ldr;
      end
      ST_STO:  ctl.rf_write = ~is_nop & (is_alu | is_ldr);
      default: ;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_FMAR, ST_FMEM, ST_FIR: phase = PH_FETCH;
      ST_DEC:  phase = PH_DECODE;
      ST_EVA:  phase = PH_EVAL;
      ST_OPS:  phase = PH_OPER;
      ST_EXE:  phase = PH_EXEC;
      ST_STO:  phase = PH_STORE;
      default: phase = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int              DW       = 16,
  parameter int              NUM_REGS = 8,
  parameter int              OPW      = 4,
  parameter int              OFS_W    = 6,
  parameter logic [DW-1:0]   RESET_PC = 16'h3000,
  localparam int             RAW      = $clog2(NUM_REGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic [2:0]     phase,
  output logic [DW-1:0]  pc,
  output logic           wb_valid,
  output logic [RAW-1:0] wb_reg,
  output logic [DW-1:0]  wb_data
);

  localparam int OP_LSB   = DW - OPW;
  localparam int DST_LSB  = OP_LSB - RAW;
  localparam int SRC1_LSB = DST_LSB - RAW;

  logic [1:0]    rs_q;
  logic          rst_int_n;
  ctrl_t         ctl;
  phase_e        ph;
  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q, opa_q, opb_q, res_q;
  logic [DW-1:0] rd_a, rd_b, alu_y, ibus, eff_addr, ofs_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  seq_ctrl #(.OPW(OPW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mem_ready (mem_ready),
    .opcode    (ir_q[DW-1:OP_LSB]),
    .ctl       (ctl),
    .phase     (ph)
  );

  seq_regfile #(.DW(DW), .NR(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (ctl.rf_write),
    .waddr (ir_q[DST_LSB +: RAW]),
    .wdata (res_q),
    .ra_a  (ir_q[SRC1_LSB +: RAW]),
    .ra_b  (ir_q[RAW-1:0]),
    .rd_a  (rd_a),
    .rd_b  (rd_b)
  );

  seq_alu #(.DW(DW)) u_alu (
    .a   (opa_q),
    .b   (opb_q),
    .sel (ctl.alu_sel),
    .y   (alu_y)
  );

  assign ofs_ext  = {{(DW-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};
  assign eff_addr = rd_a + ofs_ext;

  always_comb begin
    ibus = '0;
    if (ctl.gate_alu) begin
      ibus = alu_y;
    end else if (ctl.gate_mdr) begin
      ibus = mdr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= RESET_PC;
    end else if (ctl.pc_inc) begin
      pc_q <= pc_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mar_q <= '0;
    end else if (ctl.mar_from_pc) begin
      mar_q <= pc_q;
    end else if (ctl.mar_from_ea) begin
      mar_q <= eff_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mdr_q <= '0;
    end else if (ctl.mdr_load) begin
      mdr_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ir_q <= '0;
    end else if (ctl.ir_load) begin
      ir_q <= mdr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (ctl.opnd_load) begin
      opa_q <= rd_a;
      opb_q <= rd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
    end else if (ctl.res_load) begin
      res_q <= ibus;
    end
  end

  assign mem_req  = ctl.mem_req;
  assign mem_addr = mar_q;
  assign phase    = ph;
  assign pc       = pc_q;
  assign wb_valid = ctl.rf_write;
  assign wb_reg   = ir_q[DST_LSB +: RAW];
  assign wb_data  = res_q;

endmodule

// File: rtl/seq_checks.sv
module seq_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  phase,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [15:0] mem_addr,
  input logic [15:0] pc,
  input logic        wb_valid,
  input logic [3:0]  ir_op
);

  // R1: a phase change only ever moves to the next phase, wrapping after store
  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |->
      (phase == (($past(phase) == 3'd5) ? 3'd0 : ($past(phase) + 3'd1))));

  // R4 and R8: an unanswered request is held with a stable address
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R3: the first fetch cycle after store advances the counter by one
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !mem_req && $past(phase) == 3'd5) |=>
      (pc == $past(pc) + 16'd1));

  // R10: writes appear only in the store-result phase
  a_r10_wb_store: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (phase == 3'd5));

  // R9: only the four supported opcodes ever write
  a_r9_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (ir_op == 4'b0001 || ir_op == 4'b0101 ||
                  ir_op == 4'b1001 || ir_op == 4'b0110));

  // R3: the counter never moves outside the fetch phase
  a_r3_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0) |=> $stable(pc));

endmodule

bind instr_cycle_seq seq_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .pc        (pc),
  .wb_valid  (wb_valid),
  .ir_op     (ir_q[15:12])
);

// File: tb/sim_instr_cycle_seq.sv
module sim_instr_cycle_seq;

  typedef struct {
    int    ph;
    int    pcv;
    bit    req;
    int    addr;
    string rtag;
    bit    wbv;
    int    wreg;
    int    wdat;
    string wtag;
  } exp_t;

  localparam int START = 'h3000;
  localparam int NINSTR = 10;
  localparam int WATCHDOG = 5000;

  logic        clk;
  logic        rst_n;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        mem_ready;
  logic [2:0]  phase;
  logic [15:0] pc;
  logic        wb_valid;
  logic [2:0]  wb_reg;
  logic [15:0] wb_data;

  logic [15:0] mem [int];
  exp_t        q[$];
  int          n_chk;
  int          n_fail;
  int          cyc;
  int          m_acc;
  int          m_cnt;
  int          m_lat;
  bit          m_busy;

  instr_cycle_seq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .phase     (phase),
    .pc        (pc),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic exp_t mk(input int ph, input int pcv);
    exp_t e;
    e.ph = ph; e.pcv = pcv; e.req = 0; e.addr = 0; e.rtag = "R4";
    e.wbv = 0; e.wreg = 0; e.wdat = 0; e.wtag = "R10";
    return e;
  endfunction

  task automatic build_model();
    bit [15:0] r [8];
    int acc;
    int a;
    exp_t e;
    for (int i = 0; i < 8; i++) r[i] = 16'h0;
    acc = 0;
    a = START;
    q.push_back(mk(0, START));
    for (int k = 0; k < NINSTR; k++) begin
      bit [15:0] ins, ea, val;
      int op, d, s1, s2, lat;
      ins = rd(a);
      op = int'(ins[15:12]); d = int'(ins[11:9]);
      s1 = int'(ins[8:6]);   s2 = int'(ins[2:0]);
      q.push_back(mk(0, a));
      lat = acc % 4; acc++;
      for (int w = 0; w <= lat; w++) begin
        e = mk(0, a + 1); e.req = 1; e.addr = a; e.rtag = "R4";
        q.push_back(e);
      end
      q.push_back(mk(0, a + 1));
      q.push_back(mk(1, a + 1));
      q.push_back(mk(2, a + 1));
      ea = r[s1] + {{10{ins[5]}}, ins[5:0]};
      if (op == 6) begin
        lat = acc % 4; acc++;
        for (int w = 0; w <= lat; w++) begin
          e = mk(3, a + 1); e.req = 1; e.addr = int'(ea); e.rtag = "R8";
          q.push_back(e);
        end
      end else begin
        q.push_back(mk(3, a + 1));
      end
      q.push_back(mk(4, a + 1));
      e = mk(5, a + 1);
      e.wreg = d;
      case (op)
        1: begin val = r[s1] + r[s2]; e.wbv = 1; e.wtag = "R5 R10"; end
        5: begin val = r[s1] & r[s2]; e.wbv = 1; e.wtag = "R6 R10"; end
        9: begin val = ~r[s1];        e.wbv = 1; e.wtag = "R7 R10"; end
        6: begin val = rd(int'(ea));  e.wbv = 1; e.wtag = "R8 R10"; end
        default: begin val = 16'h0;   e.wbv = 0; e.wtag = "R9"; end
      endcase
      e.wdat = int'(val);
      if (e.wbv) r[d] = val;
      q.push_back(e);
      a = a + 1;
    end
    q.push_back(mk(0, a));
  endtask

  task automatic drive_mem();
    if (mem_req) begin
      if (!m_busy) begin
        m_busy = 1; m_cnt = 0; m_lat = m_acc % 4; m_acc++;
      end
      if (m_cnt == m_lat) begin
        mem_ready = 1'b1;
        mem_rdata = rd(int'(mem_addr));
      end else begin
        mem_ready = 1'b0;
      end
      m_cnt++;
    end else begin
      m_busy = 0;
      mem_ready = 1'b0;
      mem_rdata = 16'h0;
    end
  endtask

  initial begin
    exp_t e;
    bit   hung;
    n_chk = 0; n_fail = 0; cyc = 0; m_acc = 0; m_cnt = 0; m_lat = 0; m_busy = 0;
    hung = 0;
    rst_n = 1'b0; mem_ready = 1'b0; mem_rdata = 16'h0;
    // program: two loads (positive, negative offset), ADD with [5:3] set,
    // AND, NOT, load with base register and most negative offset,
    // ADD that wraps, ADD onto its own source, unsupported opcode, AND
    mem[START + 0] = 16'h6205;
    mem[START + 1] = 16'h643D;
    mem[START + 2] = 16'h167A;
    mem[START + 3] = 16'h5842;
    mem[START + 4] = 16'h9A7F;
    mem[START + 5] = 16'h6C60;
    mem[START + 6] = 16'h1F45;
    mem[START + 7] = 16'h1241;
    mem[START + 8] = 16'hF025;
    mem[START + 9] = 16'h5187;
    mem['h0005]    = 16'h1234;
    mem['hFFFD]    = 16'h00FF;
    mem['h1214]    = 16'hBEEF;
    build_model();

    repeat (3) begin
      @(negedge clk);
      check(phase == 3'd0, "R2", "reset phase", int'(phase), 0);
      check(pc == 16'h3000, "R2", "reset pc", int'(pc), 'h3000);
      check(!mem_req && !wb_valid, "R2", "reset req/wb", int'({mem_req, wb_valid}), 0);
      drive_mem();
    end
    rst_n = 1'b1;

    while (q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        hung = 1;
        break;
      end
      e = q.pop_front();
      check(int'(phase) == e.ph, "R1 R11", "phase", int'(phase), e.ph);
      check(int'(pc) == e.pcv, "R3", "pc", int'(pc), e.pcv);
      check(mem_req == e.req, e.rtag, "mem_req", int'(mem_req), int'(e.req));
      if (e.req)
        check(int'(mem_addr) == e.addr, e.rtag, "mem_addr", int'(mem_addr), e.addr);
      check(wb_valid == e.wbv, e.wtag, "wb_valid", int'(wb_valid), int'(e.wbv));
      if (e.wbv) begin
        check(int'(wb_reg) == e.wreg, e.wtag, "wb_reg", int'(wb_reg), e.wreg);
        check(int'(wb_data) == e.wdat, e.wtag, "wb_data", int'(wb_data), e.wdat);
      end
      drive_mem();
    end
    if (hung) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule